// File: doc/BRIEF.md
# Multi-Queue Descriptor Ring Pointer Register Block

This block holds the per-queue ring state for one direction of a DMA engine that serves sixteen queues. Each queue owns a descriptor ring: software programs its base address and length, posts work by writing a descriptor count to a doorbell register, and watches a status word that reports how many descriptors are still pending. All pointers and the length count whole descriptors, never bytes. The ring base is 64-byte aligned, so its six low address bits are not stored.

The engine side of the block is a small port. The descriptor prefetcher picks a queue, reads its pending count and asks for the head to move by one descriptor. The same port lets the engine raise the queue's in-barrier flag and step the completion-ring head. Software reaches every register through a plain memory-mapped read/write bus. Reads return data in the same cycle, and writes take effect at the next clock edge. Descriptor fetch, scheduling and bus mastering are not part of this block.

Top module: `dmaq_regfile`

## Requirements
- R1: After reset, every register of every queue reads zero, including the status word.
- R2: Queue q (0..15) owns the 4 KiB window at byte address 0x1000 + q*0x1000. The word offsets inside the window are: config 0x20, status 0x24, ring base low 0x28, ring base high 0x2C, ring length 0x30, head 0x34, tail increment 0x38, tail 0x3C, completion base low 0x44, completion head 0x4C and software reset 0xB0. Config and ring base high store all 32 bits. Ring base low and completion base low keep bits [31:6] and read bits [5:0] as zero. Ring length keeps bits [23:0].
- R3: A write to the tail increment register sets tail = (tail + (wdata & 0xFFFFFF)) mod length. Bits [31:24] of the written value have no effect.
- R4: Head and tail are read-only, so a bus write to either leaves it unchanged. Status is also read-only. The tail increment and software reset registers read as zero.
- R5: Status bits [24:0] and the port eng_used both report used = (tail - head) mod length. Status bit 31 (full) is 1 exactly when used = length - 1.
- R6: An engine head advance on queue eng_qsel is accepted only when config bit 16 is 1 and used is nonzero. When it is accepted, eng_ack is 1 in the same cycle and the head becomes (head + 1) mod length. When it is not accepted, the head does not change and eng_ack is 0.
- R7: Status bit 29 equals config bit 17 AND (used != 0). Status bit 28 equals config bit 16 AND (used != 0).
- R8: A pulse on eng_barrier sets the selected queue's in-barrier flag, which reads as status bit 30. A software reset write with bit 0 set clears the flag.
- R9: A software reset write clears state according to its bits. Bit 1 clears the tail, bit 2 clears the head, and bit 8 clears every register of that queue. The reset bits are not stored.
- R10: Writing the ring length clears the head, the tail and the completion head. While the length is below 2, doorbells leave the tail at zero and used stays zero.
- R11: A pulse on eng_cadv sets the completion head to (completion head + 1) mod length. The completion head reads at offset 0x4C.
- R12: A register write, doorbell or reset on one queue leaves every other queue unchanged. Addresses outside the sixteen queue windows read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| eng_qsel | input | 4 | Queue that the engine port addresses |
| eng_adv | input | 1 | Request to advance the head by one descriptor |
| eng_cadv | input | 1 | Advance the completion head by one descriptor |
| eng_barrier | input | 1 | Set the in-barrier flag |
| eng_used | output | 25 | Pending descriptor count of the selected queue |
| eng_ack | output | 1 | Head advance accepted this cycle |

## Verification
The hardest states to reach are the wrap-around corners. These are a doorbell count larger than the whole ring, a tail that wraps past the head until the ring is exactly one slot short of full, and a head advance requested on a ring that has just drained. The bench reaches them by sweeping ring lengths 1 through 7 on three queues. For each length it applies every doorbell count from zero to past twice the length, plus the largest 24-bit count. Between doorbells it interleaves bursts of head advances, so the pointer pair passes through the empty, partial and full relations many times.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned INC_W     = 24;
  localparam int unsigned USED_W    = 25;

  localparam logic [OFF_W-1:0] OFF_CFG   = 12'h020;
  localparam logic [OFF_W-1:0] OFF_STAT  = 12'h024;
  localparam logic [OFF_W-1:0] OFF_BLO   = 12'h028;
  localparam logic [OFF_W-1:0] OFF_BHI   = 12'h02C;
  localparam logic [OFF_W-1:0] OFF_LEN   = 12'h030;
  localparam logic [OFF_W-1:0] OFF_HEAD  = 12'h034;
  localparam logic [OFF_W-1:0] OFF_TINC  = 12'h038;
  localparam logic [OFF_W-1:0] OFF_TAIL  = 12'h03C;
  localparam logic [OFF_W-1:0] OFF_CLO   = 12'h044;
  localparam logic [OFF_W-1:0] OFF_CHEAD = 12'h04C;
  localparam logic [OFF_W-1:0] OFF_SWRST = 12'h0B0;

  localparam int unsigned CFG_PREF_BIT  = 16;
  localparam int unsigned CFG_SCHED_BIT = 17;

  localparam int unsigned RST_BAR_BIT   = 0;
  localparam int unsigned RST_TAIL_BIT  = 1;
  localparam int unsigned RST_HEAD_BIT  = 2;
  localparam int unsigned RST_QUEUE_BIT = 8;
endpackage

// File: rtl/dmaq_decode.sv
module dmaq_decode #(
  parameter int unsigned NUM_Q  = 16,
  parameter int unsigned AW     = 17,
  localparam int unsigned QIDX_W = $clog2(NUM_Q),
  localparam int unsigned BLK_W  = AW - dmaq_pkg::OFF_W
) (
  input  logic [AW-1:0]                addr,
  output logic                         hit,
  output logic [QIDX_W-1:0]            qidx,
  output logic [dmaq_pkg::OFF_W-1:0]   off
);
  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] blk_m1;

  assign blk    = addr[AW-1:dmaq_pkg::OFF_W];
  assign off    = addr[dmaq_pkg::OFF_W-1:0];
  assign blk_m1 = blk - BLK_W'(1);
  assign hit    = (blk >= BLK_W'(1)) && (blk <= BLK_W'(NUM_Q));
  assign qidx   = blk_m1[QIDX_W-1:0];
endmodule

// File: rtl/dmaq_queue.sv
module dmaq_queue #(
  parameter int unsigned PTR_W = 24,
  localparam int unsigned INC_W = dmaq_pkg::INC_W,
  localparam int unsigned SUM_W = ((PTR_W > INC_W) ? PTR_W : INC_W) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [dmaq_pkg::OFF_W-1:0]   wr_off,
  input  logic [31:0]                  wdata,
  input  logic [dmaq_pkg::OFF_W-1:0]   rd_off,
  output logic [31:0]                  rd_word,
  input  logic                         adv_req,
  input  logic                         cadv_req,
  input  logic                         bar_set,
  output logic [dmaq_pkg::USED_W-1:0]  used_out,
  output logic                         adv_ok
);
  import dmaq_pkg::*;

  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] p,
                                                input logic [INC_W-1:0] inc,
                                                input logic [PTR_W-1:0] len);
    logic [SUM_W-1:0] s;
    if (len < PTR_W'(2)) return '0;
    s = SUM_W'(p) + SUM_W'(inc);
    s = s % SUM_W'(len);
    return s[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] ring_used(input logic [PTR_W-1:0] t,
                                                 input logic [PTR_W-1:0] h,
                                                 input logic [PTR_W-1:0] len);
    if (len < PTR_W'(2)) return '0;
    if (t >= h) return t - h;
    return (t + len) - h;
  endfunction

  logic [31:0]      cfg;
  logic [31:6]      blo, clo;
  logic [31:0]      bhi;
  logic [PTR_W-1:0] len, head, tail, chead;
  logic             barrier;

  logic             len_wr, db_wr, sw_wr;
  logic             rst_bar, rst_tail, rst_head, rst_q;
  logic             q_live, cadv_ok, full;
  logic [PTR_W-1:0] used;
  logic [31:0]      status;

  assign len_wr   = wr_en && (wr_off == OFF_LEN);
  assign db_wr    = wr_en && (wr_off == OFF_TINC);
  assign sw_wr    = wr_en && (wr_off == OFF_SWRST);
  assign rst_bar  = sw_wr && wdata[RST_BAR_BIT];
  assign rst_tail = sw_wr && wdata[RST_TAIL_BIT];
  assign rst_head = sw_wr && wdata[RST_HEAD_BIT];
  assign rst_q    = sw_wr && wdata[RST_QUEUE_BIT];

  assign q_live   = (len >= PTR_W'(2));
  assign used     = ring_used(tail, head, len);
  assign full     = q_live && (used == len - PTR_W'(1));
  assign adv_ok   = adv_req && cfg[CFG_PREF_BIT] && (used != '0);
  assign cadv_ok  = cadv_req && q_live;
  assign used_out = USED_W'(used);

  assign status = {full, barrier, cfg[CFG_SCHED_BIT] && (used != '0),
                   cfg[CFG_PREF_BIT] && (used != '0), 3'b000, USED_W'(used)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; blo <= '0; bhi <= '0; clo <= '0; len <= '0;
      head <= '0; tail <= '0; chead <= '0; barrier <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_CFG: cfg <= wdata;
          OFF_BLO: blo <= wdata[31:6];
          OFF_BHI: bhi <= wdata;
          OFF_LEN: len <= wdata[PTR_W-1:0];
          OFF_CLO: clo <= wdata[31:6];
          default: ;
        endcase
      end
      if (rst_q) begin
        cfg <= '0; blo <= '0; bhi <= '0; clo <= '0; len <= '0;
      end

      if (len_wr || rst_tail || rst_q) tail <= '0;
      else if (db_wr)                  tail <= ring_add(tail, wdata[INC_W-1:0], len);

      if (len_wr || rst_head || rst_q) head <= '0;
      else if (adv_ok)                 head <= ring_add(head, INC_W'(1), len);

      if (len_wr || rst_q)             chead <= '0;
      else if (cadv_ok)                chead <= ring_add(chead, INC_W'(1), len);

      if (rst_bar || rst_q)            barrier <= 1'b0;
      else if (bar_set)                barrier <= 1'b1;
    end
  end

  always_comb begin
    case (rd_off)
      OFF_CFG:   rd_word = cfg;
      OFF_STAT:  rd_word = status;
      OFF_BLO:   rd_word = {blo, 6'b0};
      OFF_BHI:   rd_word = bhi;
      OFF_LEN:   rd_word = 32'(len);
      OFF_HEAD:  rd_word = 32'(head);
      OFF_TAIL:  rd_word = 32'(tail);
      OFF_CLO:   rd_word = {clo, 6'b0};
      OFF_CHEAD: rd_word = 32'(chead);
      default:   rd_word = '0;
    endcase
  end

  AST_HEAD_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_req && used == '0 && !wr_en) |=> $stable(head)); // R6
  AST_USED_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    q_live |-> (used < len)); // R5
  AST_TAIL_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_TAIL) |=> $stable(tail)); // R4
  AST_HEAD_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_HEAD && !adv_req) |=> $stable(head)); // R4
  AST_SWRST_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_tail |=> (tail == '0)); // R9
  AST_LEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr |=> (head == '0 && tail == '0 && chead == '0)); // R10
endmodule

// File: rtl/dmaq_regfile.sv
module dmaq_regfile #(
  parameter int unsigned NUM_Q = 16,
  parameter int unsigned AW    = 17,
  parameter int unsigned PTR_W = 24,
  localparam int unsigned QIDX_W = $clog2(NUM_Q)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [AW-1:0]               bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [QIDX_W-1:0]           eng_qsel,
  input  logic                        eng_adv,
  input  logic                        eng_cadv,
  input  logic                        eng_barrier,
  output logic [dmaq_pkg::USED_W-1:0] eng_used,
  output logic                        eng_ack
);
  import dmaq_pkg::*;

  logic              hit;
  logic [QIDX_W-1:0] qidx;
  logic [OFF_W-1:0]  off;
  logic [31:0]       q_rd   [NUM_Q];
  logic [USED_W-1:0] q_used [NUM_Q];
  logic [NUM_Q-1:0]  q_ack;

  dmaq_decode #(.NUM_Q(NUM_Q), .AW(AW)) u_dec (
    .addr(bus_addr), .hit(hit), .qidx(qidx), .off(off)
  );

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic sel_bus, sel_eng;
    assign sel_bus = hit && (qidx == QIDX_W'(i));
    assign sel_eng = (eng_qsel == QIDX_W'(i));

    dmaq_queue #(.PTR_W(PTR_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && sel_bus), .wr_off(off), .wdata(bus_wdata),
      .rd_off(off), .rd_word(q_rd[i]),
      .adv_req(eng_adv && sel_eng), .cadv_req(eng_cadv && sel_eng),
      .bar_set(eng_barrier && sel_eng),
      .used_out(q_used[i]), .adv_ok(q_ack[i])
    );
  end

  assign bus_rdata = (bus_rd && hit) ? q_rd[qidx] : '0;
  assign eng_used  = q_used[eng_qsel];
  assign eng_ack   = |q_ack;

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_ack)); // R6
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack |-> (eng_adv && eng_used != '0)); // R6
endmodule

// File: tb/tb_dmaq_regfile.sv
module tb_dmaq_regfile;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [16:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  eng_qsel = '0;
  logic        eng_adv = 0, eng_cadv = 0, eng_barrier = 0;
  logic [24:0] eng_used;
  logic        eng_ack;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  dmaq_regfile dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [16:0] qa(int q, logic [11:0] o);
    return 17'((q + 1) * 32'h1000) | 17'(o);
  endfunction

  task automatic wr(int q, logic [11:0] o, logic [31:0] d);
    @(negedge clk);
    bus_addr = qa(q, o); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int q, logic [11:0] o, output logic [31:0] d);
    @(negedge clk);
    bus_addr = qa(q, o); bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic eng(int q, bit adv, bit cadv, bit bar, output bit ack, output logic [24:0] u);
    @(negedge clk);
    eng_qsel = 4'(q); eng_adv = adv; eng_cadv = cadv; eng_barrier = bar;
    #1 ack = eng_ack; u = eng_used;
    @(negedge clk);
    eng_adv = 0; eng_cadv = 0; eng_barrier = 0;
  endtask

  function automatic longint m_add(longint p, longint inc, longint len);
    return (len < 2) ? 0 : (p + inc) % len;
  endfunction
  function automatic longint m_used(longint t, longint h, longint len);
    return (len < 2) ? 0 : (t - h + len) % len;
  endfunction
  function automatic logic [31:0] m_stat(longint t, longint h, longint len, logic [31:0] cfg, bit bar);
    longint u = m_used(t, h, len);
    logic [31:0] s = 32'(u);
    s[31] = (len >= 2) && (u == len - 1);
    s[30] = bar;
    s[29] = cfg[17] && (u != 0);
    s[28] = cfg[16] && (u != 0);
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [24:0] u;
    bit ack;
    int qs[3] = '{0, 5, 15};
    logic [11:0] offs[11] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034,
                              12'h038, 12'h03C, 12'h044, 12'h04C, 12'h0B0};

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state on first and last queue
    foreach (offs[k]) begin
      rd(0, offs[k], d);  chk("R1 q0", d, 0);
      rd(15, offs[k], d); chk("R1 q15", d, 0);
    end

    // R2: read/write registers and window placement
    wr(3, 12'h020, 32'hDEAD_BEEF); rd(3, 12'h020, d); chk("R2 cfg", d, 32'hDEAD_BEEF);
    wr(3, 12'h028, 32'hFFFF_FFFF); rd(3, 12'h028, d); chk("R2 base lo", d, 32'hFFFF_FFC0);
    wr(3, 12'h02C, 32'h1234_5678); rd(3, 12'h02C, d); chk("R2 base hi", d, 32'h1234_5678);
    wr(3, 12'h030, 32'hFFFF_FFFF); rd(3, 12'h030, d); chk("R2 len", d, 32'h00FF_FFFF);
    rd(2, 12'h02C, d); chk("R12 neighbour base hi", d, 0);
    rd(4, 12'h020, d); chk("R12 neighbour cfg", d, 0);
    // R11: completion base low
    wr(3, 12'h044, 32'hABCD_EF7F); rd(3, 12'h044, d); chk("R11 comp base lo", d, 32'hABCD_EF40);
    // R12: outside windows
    @(negedge clk); bus_addr = 17'h00020; bus_rd = 1; #1 chk("R12 below window", bus_rdata, 0); bus_rd = 0;
    @(negedge clk); bus_addr = 17'h1_1020; bus_rd = 1; #1 chk("R12 above window", bus_rdata, 0); bus_rd = 0;

    // R4: read-only and write-only registers
    wr(3, 12'h030, 32'd8);
    wr(3, 12'h038, 32'd5);
    wr(3, 12'h03C, 32'd1); rd(3, 12'h03C, d); chk("R4 tail ro", d, 5);
    wr(3, 12'h034, 32'd3); rd(3, 12'h034, d); chk("R4 head ro", d, 0);
    wr(3, 12'h024, 32'hFFFF_FFFF); rd(3, 12'h024, d); chk("R4 status ro", d, m_stat(5, 0, 8, 32'hDEAD_BEEF, 0));
    rd(3, 12'h038, d); chk("R4 tinc reads 0", d, 0);
    rd(3, 12'h0B0, d); chk("R4 swrst reads 0", d, 0);

    // R3/R5/R6/R7/R10: sweep of ring lengths and doorbell counts
    foreach (qs[qi]) begin
      int q = qs[qi];
      logic [31:0] cfg = 32'h0003_0000;
      wr(q, 12'h020, cfg);
      for (int len = 1; len <= 7; len++) begin
        longint t = 0, h = 0;
        wr(q, 12'h030, 32'(len));
        rd(q, 12'h034, d); chk("R10 head cleared", d, 0);
        rd(q, 12'h03C, d); chk("R10 tail cleared", d, 0);
        for (int inc = 0; inc <= 2 * len + 2; inc++) begin
          int iv = (inc == 2 * len + 2) ? 32'h00FF_FFFF : inc;
          wr(q, 12'h038, {8'hA5, 24'(iv)});
          t = m_add(t, iv, len);
          rd(q, 12'h03C, d); chk("R3 tail after doorbell", d, 32'(t));
          rd(q, 12'h024, d); chk("R5 R7 status", d, m_stat(t, h, len, cfg, 0));
          for (int k = 0; k < (inc % 4); k++) begin
            bit exp_ack = (m_used(t, h, len) != 0);
            eng(q, 1, 0, 0, ack, u);
            chk("R5 eng_used", 32'(u), 32'(m_used(t, h, len)));
            chk("R6 ack", 32'(ack), 32'(exp_ack));
            if (exp_ack) h = m_add(h, 1, len);
            rd(q, 12'h034, d); chk("R6 head", d, 32'(h));
          end
        end
      end
    end

    // R6: disabled queue ignores head advance
    wr(6, 12'h030, 32'd4); wr(6, 12'h038, 32'd2);
    eng(6, 1, 0, 0, ack, u);
    chk("R6 disabled no ack", 32'(ack), 0);
    rd(6, 12'h034, d); chk("R6 disabled head", d, 0);
    // R7: scheduler only
    wr(6, 12'h020, 32'h0002_0000);
    rd(6, 12'h024, d); chk("R7 sched only", d, m_stat(2, 0, 4, 32'h0002_0000, 0));

    // R8: barrier flag
    eng(6, 0, 0, 1, ack, u);
    rd(6, 12'h024, d); chk("R8 barrier set", d, m_stat(2, 0, 4, 32'h0002_0000, 1));
    wr(6, 12'h0B0, 32'h1);
    rd(6, 12'h024, d); chk("R8 barrier cleared", d, m_stat(2, 0, 4, 32'h0002_0000, 0));

    // R11: completion head wrap
    for (int k = 1; k <= 5; k++) begin
      eng(6, 0, 1, 0, ack, u);
      rd(6, 12'h04C, d); chk("R11 comp head", d, 32'(k % 4));
    end

    // R9: software reset bits, R12 isolation
    wr(2, 12'h030, 32'd5); wr(2, 12'h020, 32'h0001_0000); wr(2, 12'h038, 32'd3);
    wr(7, 12'h020, 32'h0001_0000); wr(7, 12'h030, 32'd6); wr(7, 12'h038, 32'd4);
    eng(7, 1, 0, 0, ack, u); eng(7, 1, 0, 0, ack, u);
    wr(7, 12'h0B0, 32'h2);
    rd(7, 12'h03C, d); chk("R9 tail reset", d, 0);
    rd(7, 12'h034, d); chk("R9 head kept", d, 2);
    wr(7, 12'h0B0, 32'h4);
    rd(7, 12'h034, d); chk("R9 head reset", d, 0);
    wr(7, 12'h028, 32'h0000_1000);
    wr(7, 12'h038, 32'd2);
    wr(7, 12'h0B0, 32'h100);
    foreach (offs[k]) begin
      rd(7, offs[k], d); chk("R9 queue reset", d, 0);
    end
    rd(2, 12'h03C, d); chk("R12 other queue tail", d, 3);
    rd(2, 12'h030, d); chk("R12 other queue len", d, 5);

    // R10: length below 2 keeps pointers at zero
    wr(8, 12'h030, 32'd1); wr(8, 12'h038, 32'd5);
    rd(8, 12'h03C, d); chk("R10 len1 tail", d, 0);
    rd(8, 12'h024, d); chk("R10 len1 status", d, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule